// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Selector

This block chooses which hardware thread launches an instruction each cycle in a processor that runs many threads and has no data cache. Every fetched instruction carries a 3-bit lookahead count. The count says how many of the instructions that follow it in the same thread do not depend on it. The selector does no dependence checking of its own. For each thread it tracks the oldest instruction that has not yet completed, which is the blocking instruction, and the number of younger instructions that may still issue past it.

A blocking instruction that is not a memory operation completes on its own once it has spent the pipeline depth in the pipe. A blocking memory operation waits for a completion event from the memory system. When several threads are eligible, a rotating pointer decides between them so that none of them starves. The launch strobe and the thread number are registered outputs.

Top module: `mt_issue_sel`

## Requirements
- R1: A synchronous reset drives `issue_vld` low on the following cycle, clears every thread's blocking state, and points the rotation at thread 0.
- R2: At most one instruction launches per cycle. A launch goes only to a thread whose `fetch_vld` bit was high in the cycle of the decision, and no strobe appears when no thread presents an instruction.
- R3: Thread t's lookahead count is `fetch_la[3t+2:3t]` (0 to 7). When a thread with no blocker issues, that instruction becomes its blocker with budget L. Each later issue while the blocker is pending uses one unit of budget. At zero budget the thread may not issue until the blocker completes.
- R4: A non-memory blocker completes PIPE_DEPTH-1 cycles after it issued. With a valid instruction held, a lone thread with lookahead L strobes in cycle k after its first launch exactly when (k mod PIPE_DEPTH) <= L. So L=0 gives one launch per PIPE_DEPTH cycles, and L >= PIPE_DEPTH-1 gives a launch every cycle.
- R5: If `fetch_mem[t]` is high when a thread's blocker issues, the blocker completes only on a `mem_done` pulse carrying that thread's number. The thread can launch again at the second clock edge after the pulse, so the strobe follows one cycle after the completion is absorbed.
- R6: A `mem_done` pulse carrying another thread's number leaves a blocked thread blocked.
- R7: Eligible threads are served in rotating order. After thread g launches, the search for the next launch starts at thread g+1 and wraps past the highest thread to thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | THREADS | Per-thread fetched instruction present |
| fetch_la | input | 3*THREADS | Per-thread lookahead count, 3 bits per thread |
| fetch_mem | input | THREADS | Per-thread instruction is a long-latency memory operation |
| mem_done | input | 1 | Memory completion event |
| mem_done_tid | input | TID_W | Thread that the completion belongs to |
| issue_vld | output | 1 | Launch strobe, registered |
| issue_tid | output | TID_W | Thread launched, registered |

## Verification
The bench sweeps every lookahead value from 0 to 7 on a single thread. It checks the exact launch pattern over three pipeline periods: a design that counts the budget off by one, or clears the blocker a cycle early or late, shifts the gap in the pattern and is caught cycle by cycle. The same sweep is repeated with memory blockers to confirm that exactly L+1 launches occur before the thread stalls. A completion tagged with the wrong thread must release nothing, and the correct completion must release the thread with exactly one cycle of delay; a selector that matched the thread number carelessly, or restored eligibility in the same cycle, would launch early. Full and sparse thread sets check the rotation order and the wrap from the top thread back to thread 0.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;
  localparam int LA_W = 3;

  typedef struct packed {
    logic            busy;
    logic            mem_blk;
    logic [LA_W-1:0] budget;
  } blk_state_t;
endpackage

// File: rtl/mt_thread_ctx.sv
module mt_thread_ctx
  import mt_issue_pkg::*;
#(
  parameter int PIPE_DEPTH = 21,
  localparam int TMR_W = $clog2(PIPE_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fv,
  input  logic [LA_W-1:0] la,
  input  logic            is_mem,
  input  logic            launch,
  input  logic            done_hit,
  output logic            elig
);
  blk_state_t       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             retire;

  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PIPE_DEPTH - 1);

  assign retire = st_q.busy &&
                  ((!st_q.mem_blk && tmr_q == TMR_W'(1)) ||
                   ( st_q.mem_blk && done_hit));

  assign elig = fv && (!st_q.busy || st_q.budget != '0);

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    if (st_q.busy && !st_q.mem_blk && tmr_q > TMR_W'(1))
      tmr_d = tmr_q - TMR_W'(1);
    if (launch && (retire || !st_q.busy)) begin
      st_d.busy    = 1'b1;
      st_d.mem_blk = is_mem;
      st_d.budget  = la;
      tmr_d        = TMR_LOAD;
    end else if (retire) begin
      st_d.busy    = 1'b0;
      st_d.mem_blk = 1'b0;
      st_d.budget  = '0;
      tmr_d        = '0;
    end else if (launch) begin
      st_d.budget  = st_q.budget - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end
endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int THREADS = 128,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [THREADS-1:0] req,
  output logic [THREADS-1:0] grant,
  output logic               any,
  output logic [TID_W-1:0]   gidx
);
  logic [TID_W-1:0] ptr_q;

  always_comb begin
    logic [TID_W:0] idx;
    grant = '0;
    any   = 1'b0;
    gidx  = '0;
    for (int i = 0; i < THREADS; i++) begin
      idx = {1'b0, ptr_q} + (TID_W+1)'(i);
      if (idx >= (TID_W+1)'(THREADS))
        idx = idx - (TID_W+1)'(THREADS);
      if (!any && req[idx[TID_W-1:0]]) begin
        any                  = 1'b1;
        gidx                 = idx[TID_W-1:0];
        grant[idx[TID_W-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (any)
      ptr_q <= (gidx == TID_W'(THREADS - 1)) ? '0 : gidx + 1'b1;
  end
endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
  import mt_issue_pkg::*;
#(
  parameter int THREADS    = 128,
  parameter int PIPE_DEPTH = 21,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [THREADS-1:0]      fetch_vld,
  input  logic [LA_W*THREADS-1:0] fetch_la,
  input  logic [THREADS-1:0]      fetch_mem,
  input  logic                    mem_done,
  input  logic [TID_W-1:0]        mem_done_tid,
  output logic                    issue_vld,
  output logic [TID_W-1:0]        issue_tid
);
  logic [THREADS-1:0] elig;
  logic [THREADS-1:0] grant;
  logic               any;
  logic [TID_W-1:0]   gidx;

  for (genvar t = 0; t < THREADS; t++) begin : g_ctx
    mt_thread_ctx #(.PIPE_DEPTH(PIPE_DEPTH)) u_ctx (
      .clk      (clk),
      .rst      (rst),
      .fv       (fetch_vld[t]),
      .la       (fetch_la[LA_W*t +: LA_W]),
      .is_mem   (fetch_mem[t]),
      .launch   (grant[t]),
      .done_hit (mem_done && mem_done_tid == TID_W'(t)),
      .elig     (elig[t])
    );
  end

  mt_rr_pick #(.THREADS(THREADS)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (elig),
    .grant (grant),
    .any   (any),
    .gidx  (gidx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_vld <= 1'b0;
      issue_tid <= '0;
    end else begin
      issue_vld <= any;
      issue_tid <= gidx;
    end
  end
endmodule

// File: rtl/mt_issue_sel_chk.sv
module mt_issue_sel_chk #(
  parameter int THREADS = 128,
  localparam int TID_W = $clog2(THREADS)
) (
  input logic               clk,
  input logic               rst,
  input logic [THREADS-1:0] fetch_vld,
  input logic [THREADS-1:0] elig,
  input logic [THREADS-1:0] grant,
  input logic               issue_vld,
  input logic [TID_W-1:0]   issue_tid
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !issue_vld);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld == '0) |=> !issue_vld);

  a_r3_grant_eligible: assert property (@(posedge clk) disable iff (rst)
    (grant & ~elig) == '0);

  a_r2_strobe_had_fetch: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> issue_vld);
endmodule

bind mt_issue_sel mt_issue_sel_chk #(.THREADS(THREADS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fetch_vld (fetch_vld),
  .elig      (elig),
  .grant     (grant),
  .issue_vld (issue_vld),
  .issue_tid (issue_tid)
);

// File: tb/test_mt_issue_sel.sv
`timescale 1ns/1ps
module test_mt_issue_sel;
  localparam int T = 4;
  localparam int D = 6;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [T-1:0]  fetch_vld;
  logic [3*T-1:0] fetch_la;
  logic [T-1:0]  fetch_mem;
  logic          mem_done;
  logic [TW-1:0] mem_done_tid;
  logic          issue_vld;
  logic [TW-1:0] issue_tid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mt_issue_sel #(.THREADS(T), .PIPE_DEPTH(D)) i_mt_issue_sel (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_la(fetch_la),
    .fetch_mem(fetch_mem), .mem_done(mem_done), .mem_done_tid(mem_done_tid),
    .issue_vld(issue_vld), .issue_tid(issue_tid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_vld = '0; fetch_la = '0; fetch_mem = '0;
    mem_done = 1'b0; mem_done_tid = '0;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fetch_vld = '0; fetch_la = '0; fetch_mem = '0;
    mem_done = 1'b0; mem_done_tid = '0;
    do_reset();
    // R1: quiet after reset
    chk(issue_vld == 1'b0, "R1", int'(issue_vld), 0);
    // R2: nothing presented, nothing launched
    repeat (3) begin
      step();
      chk(issue_vld == 1'b0, "R2", int'(issue_vld), 0);
    end

    // R3/R4: lone thread, every lookahead value, non-memory blockers
    for (int t = 0; t < T; t += 3) begin
      for (int la = 0; la < 8; la++) begin
        do_reset();
        fetch_la[3*t +: 3] = 3'(la);
        fetch_vld[t] = 1'b1;
        for (int k = 0; k < 3*D; k++) begin
          step();
          chk(issue_vld == (((k % D) <= la) ? 1'b1 : 1'b0), "R4", int'(issue_vld),
              ((k % D) <= la) ? 1 : 0);
          if (issue_vld) chk(issue_tid == TW'(t), "R3", int'(issue_tid), t);
        end
      end
    end

    // R5/R6: memory blockers
    for (int la = 0; la < 8; la++) begin
      int cnt;
      do_reset();
      fetch_la[3*2 +: 3] = 3'(la);
      fetch_mem[2] = 1'b1;
      fetch_vld[2] = 1'b1;
      cnt = 0;
      for (int k = 0; k < 14; k++) begin
        step();
        if (issue_vld) cnt++;
      end
      chk(cnt == la + 1, "R3", cnt, la + 1);
      mem_done = 1'b1; mem_done_tid = 2'd1;
      step();
      mem_done = 1'b0;
      chk(issue_vld == 1'b0, "R6", int'(issue_vld), 0);
      step();
      chk(issue_vld == 1'b0, "R6", int'(issue_vld), 0);
      mem_done = 1'b1; mem_done_tid = 2'd2;
      step();
      mem_done = 1'b0;
      chk(issue_vld == 1'b0, "R5", int'(issue_vld), 0);
      step();
      chk(issue_vld == 1'b1 && issue_tid == 2'd2, "R5", int'(issue_vld), 1);
    end

    // R7: all threads, full rotation
    do_reset();
    fetch_la = {T{3'd7}};
    fetch_vld = '1;
    for (int k = 0; k < 16; k++) begin
      step();
      chk(issue_vld && issue_tid == TW'(k % T), "R7", int'(issue_tid), k % T);
    end
    // R7: sparse set 0 and 2
    do_reset();
    fetch_la = {T{3'd7}};
    fetch_vld = 4'b0101;
    for (int k = 0; k < 8; k++) begin
      step();
      chk(issue_vld && issue_tid == TW'((k % 2) * 2), "R7", int'(issue_tid), (k % 2) * 2);
    end
    // R7: sparse set 1 and 3, wrap from 3 back to 1
    do_reset();
    fetch_la = {T{3'd7}};
    fetch_vld = 4'b1010;
    for (int k = 0; k < 8; k++) begin
      step();
      chk(issue_vld && issue_tid == TW'((k % 2) * 2 + 1), "R7", int'(issue_tid), (k % 2) * 2 + 1);
    end
    // R2: withdraw all requests, strobe stops
    fetch_vld = '0;
    step();
    step();
    chk(issue_vld == 1'b0, "R2", int'(issue_vld), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule